// File: doc/BRIEF.md
# Deskew Calibration Insertion Controller

This block sits beside a camera-serial transmit path and decides when a deskew calibration burst is inserted into the outgoing stream, and what bit pattern that burst carries. Software sets control fields through a small two-register write/read port. A calibration sequence is requested either once, through a self-clearing single-shot bit, or automatically after every frame-end packet the path reports as sent. In both cases the burst waits for the next idle gap on the link. The block raises a request to the lane serializer and holds it until the serializer reports completion. It also presents an alternating-bit pattern byte whose polarity is selectable.

The block also decodes a lane override code into low-power (LP00) forcing signals for the data and clock lanes. It brings out the output-enable and continuous-clock settings. It folds per-port enable and valid-video flags into one pass status, either in an any-port mode or an all-ports mode.

Top module: `skewcal_top`

## Requirements
- R1: After reset every control field reads back 0, and `tx_enable`, `hs_clk_cont`, `cal_req`, `data_lp00` and `clk_lp00` are 0.
- R2: Register address 0 holds [0] output enable (`tx_enable`), [1] continuous clock (`hs_clk_cont`) and [3:2] lane override. Address 1 holds [0] periodic enable, [1] single-shot request, [2] pattern invert and [3] pass-all mode. Every field reads back as written, except for the single-shot clearing in R6.
- R3: Lane override code 01 drives `data_lp00`=1 and `clk_lp00`=0. Code 11 drives both to 1. Codes 00 and the reserved 10 drive both to 0.
- R4: `cal_pattern` bit 0 is the first bit sent. With invert 0 the pattern alternates starting with 0 (8'hAA for 8 bits). With invert 1 it is the complement (8'h55). The polarity is captured when a sequence starts and stays stable until that sequence ends.
- R5: A pending request starts a sequence at the first clock edge at which `link_idle` is 1 and output enable is 1. `cal_req` is 1 from the following cycle.
- R6: A single-shot request yields exactly one sequence. Its bit reads 0 after the edge at which `cal_done` ends that sequence.
- R7: A `frame_end` pulse while periodic enable is 1 leaves a pending trigger. A `frame_end` pulse while periodic enable is 0 has no effect.
- R8: No sequence starts while output enable is 0. A pending request waits.
- R9: Single-shot and periodic requests pending together are served by one sequence.
- R10: `cal_req` stays 1 until `cal_done` is sampled, then drops for at least one cycle. A request arriving during a sequence is served by a later sequence.
- R11: With pass-all 0, `pass` is 1 when some enabled port is valid. With pass-all 1, `pass` is 1 when every enabled port is valid.
- R12: `pass` is 0 whenever no port is enabled, in either mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register address |
| reg_wdata | input | 4 | Register write data |
| reg_rdata | output | 4 | Register read data for `reg_addr` |
| frame_end | input | 1 | One-cycle pulse: a frame-end packet was sent |
| link_idle | input | 1 | Link is in an idle gap |
| cal_done | input | 1 | Serializer finished the calibration burst |
| rx_en | input | NPORTS | Per-port receive enable |
| rx_valid | input | NPORTS | Per-port valid-video flag |
| cal_req | output | 1 | Calibration burst requested / in progress |
| cal_pattern | output | PAT_W | Calibration pattern, bit 0 sent first |
| data_lp00 | output | 1 | Force LP00 on data lanes |
| clk_lp00 | output | 1 | Force LP00 on clock lane |
| hs_clk_cont | output | 1 | Continuous clock mode enable |
| tx_enable | output | 1 | Transmit output enable |
| pass | output | 1 | Aggregated valid-video status |

## Verification
The bench builds the block with NPORTS=4, PAT_W=8 and ADDR_W=1. Four ports keep the pass aggregation small enough to sweep every enable/valid combination in both modes, which is 512 vectors. The single address bit makes the whole register map reachable, and all four lane override codes are applied. The sequencing scenarios exercise each of the following:
- deferral to idle,
- blocking while disabled,
- merged triggers,
- requests that land mid-sequence,
- polarity capture at start.

// File: rtl/skewcal_pkg.sv
package skewcal_pkg;

  localparam int REG_W = 4;

  typedef enum logic [1:0] {
    LANE_RUN     = 2'b00,
    LANE_DATA_LP = 2'b01,
    LANE_RSVD    = 2'b10,
    LANE_ALL_LP  = 2'b11
  } lane_force_e;

  typedef struct packed {
    lane_force_e lane;
    logic        cont_clk;
    logic        out_en;
  } link_ctl_t;

  typedef struct packed {
    logic pass_all;
    logic invert;
    logic single;
    logic periodic;
  } cal_ctl_t;

  localparam int ADDR_LINK = 0;
  localparam int ADDR_CAL  = 1;

endpackage

// File: rtl/skewcal_regs.sv
module skewcal_regs
  import skewcal_pkg::*;
#(
  parameter int ADDR_W = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [REG_W-1:0]  wdata,
  input  logic              single_clr,
  output logic [REG_W-1:0]  rdata,
  output link_ctl_t         link_ctl,
  output cal_ctl_t          cal_ctl
);

  link_ctl_t link_q;
  cal_ctl_t  cal_q;
  logic      hit_link;
  logic      hit_cal;

  assign hit_link = (addr == ADDR_W'(ADDR_LINK));
  assign hit_cal  = (addr == ADDR_W'(ADDR_CAL));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      link_q <= '0;
      cal_q  <= '0;
    end else begin
      if (wr_en && hit_link) link_q <= link_ctl_t'(wdata);
      if (wr_en && hit_cal)  cal_q  <= cal_ctl_t'(wdata);
      if (single_clr)        cal_q.single <= 1'b0;
    end
  end

  always_comb begin
    rdata = '0;
    if (hit_link)     rdata = link_q;
    else if (hit_cal) rdata = cal_q;
  end

  assign link_ctl = link_q;
  assign cal_ctl  = cal_q;

endmodule

// File: rtl/skewcal_lane.sv
module skewcal_lane
  import skewcal_pkg::*;
(
  input  lane_force_e code,
  output logic        data_lp,
  output logic        clk_lp
);

  always_comb begin
    data_lp = 1'b0;
    clk_lp  = 1'b0;
    case (code)
      LANE_DATA_LP: data_lp = 1'b1;
      LANE_ALL_LP: begin
        data_lp = 1'b1;
        clk_lp  = 1'b1;
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/skewcal_pass.sv
module skewcal_pass #(
  parameter int NPORTS = 4
) (
  input  logic [NPORTS-1:0] en,
  input  logic [NPORTS-1:0] valid,
  input  logic              all_mode,
  output logic              pass
);

  function automatic logic pass_eval(input logic [NPORTS-1:0] e,
                                     input logic [NPORTS-1:0] v,
                                     input logic              m);
    logic any_en;
    logic any_ok;
    logic all_ok;
    any_en = |e;
    any_ok = |(e & v);
    all_ok = &(v | ~e);
    return any_en && (m ? all_ok : any_ok);
  endfunction

  assign pass = pass_eval(en, valid, all_mode);

endmodule

// File: rtl/skewcal_sched.sv
module skewcal_sched #(
  parameter int PAT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             out_en,
  input  logic             periodic_en,
  input  logic             single_req,
  input  logic             invert,
  input  logic             frame_end,
  input  logic             link_idle,
  input  logic             cal_done,
  output logic             cal_req,
  output logic [PAT_W-1:0] pattern,
  output logic             single_clr,
  output logic             cal_start,
  output logic             cal_finish,
  output logic             per_pend
);

  typedef enum logic {SC_IDLE = 1'b0, SC_BUSY = 1'b1} sc_state_e;

  function automatic logic [PAT_W-1:0] alt_pattern(input logic inv);
    logic [PAT_W-1:0] p;
    for (int i = 0; i < PAT_W; i++) p[i] = (i % 2 == 1) ^ inv;
    return p;
  endfunction

  sc_state_e        state_q;
  logic             per_pend_q;
  logic             took_single_q;
  logic [PAT_W-1:0] pat_q;
  logic             want;

  assign want       = single_req || per_pend_q;
  assign cal_start  = (state_q == SC_IDLE) && out_en && link_idle && want;
  assign cal_finish = (state_q == SC_BUSY) && cal_done;
  assign single_clr = cal_finish && took_single_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q       <= SC_IDLE;
      per_pend_q    <= 1'b0;
      took_single_q <= 1'b0;
      pat_q         <= alt_pattern(1'b0);
    end else begin
      if (cal_start) begin
        state_q       <= SC_BUSY;
        took_single_q <= single_req;
        pat_q         <= alt_pattern(invert);
        per_pend_q    <= 1'b0;
      end else if (cal_finish) begin
        state_q       <= SC_IDLE;
        took_single_q <= 1'b0;
      end
      if (frame_end && periodic_en) per_pend_q <= 1'b1;
    end
  end

  assign cal_req  = (state_q == SC_BUSY);
  assign pattern  = pat_q;
  assign per_pend = per_pend_q;

endmodule

// File: rtl/skewcal_top.sv
module skewcal_top
  import skewcal_pkg::*;
#(
  parameter int NPORTS = 4,
  parameter int PAT_W  = 8,
  parameter int ADDR_W = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [3:0]        reg_wdata,
  output logic [3:0]        reg_rdata,
  input  logic              frame_end,
  input  logic              link_idle,
  input  logic              cal_done,
  input  logic [NPORTS-1:0] rx_en,
  input  logic [NPORTS-1:0] rx_valid,
  output logic              cal_req,
  output logic [PAT_W-1:0]  cal_pattern,
  output logic              data_lp00,
  output logic              clk_lp00,
  output logic              hs_clk_cont,
  output logic              tx_enable,
  output logic              pass
);

  link_ctl_t link_ctl;
  cal_ctl_t  cal_ctl;
  logic      single_clr;
  logic      cal_start;
  logic      cal_finish;
  logic      per_pend;
  logic      pass_all;

  skewcal_regs #(.ADDR_W(ADDR_W)) regs_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (reg_wr),
    .addr       (reg_addr),
    .wdata      (reg_wdata),
    .single_clr (single_clr),
    .rdata      (reg_rdata),
    .link_ctl   (link_ctl),
    .cal_ctl    (cal_ctl)
  );

  skewcal_sched #(.PAT_W(PAT_W)) sched_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .out_en      (link_ctl.out_en),
    .periodic_en (cal_ctl.periodic),
    .single_req  (cal_ctl.single),
    .invert      (cal_ctl.invert),
    .frame_end   (frame_end),
    .link_idle   (link_idle),
    .cal_done    (cal_done),
    .cal_req     (cal_req),
    .pattern     (cal_pattern),
    .single_clr  (single_clr),
    .cal_start   (cal_start),
    .cal_finish  (cal_finish),
    .per_pend    (per_pend)
  );

  skewcal_lane lane_i (
    .code    (link_ctl.lane),
    .data_lp (data_lp00),
    .clk_lp  (clk_lp00)
  );

  assign pass_all = cal_ctl.pass_all;

  skewcal_pass #(.NPORTS(NPORTS)) pass_i (
    .en       (rx_en),
    .valid    (rx_valid),
    .all_mode (pass_all),
    .pass     (pass)
  );

  assign hs_clk_cont = link_ctl.cont_clk;
  assign tx_enable   = link_ctl.out_en;

endmodule

// File: rtl/skewcal_chk.sv
module skewcal_chk #(
  parameter int NPORTS = 4,
  parameter int PAT_W  = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cal_req,
  input logic              cal_done,
  input logic              link_idle,
  input logic              tx_enable,
  input logic [PAT_W-1:0]  cal_pattern,
  input logic              data_lp00,
  input logic              clk_lp00,
  input logic [NPORTS-1:0] rx_en,
  input logic [NPORTS-1:0] rx_valid,
  input logic              pass_all,
  input logic              pass,
  input logic              cal_start
);

  // R8
  start_needs_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cal_req) |-> $past(tx_enable));

  // R5
  start_needs_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cal_req) |-> $past(link_idle));

  // R10
  req_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cal_req && !cal_done) |=> cal_req);

  // R10
  req_drops_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cal_req && cal_done) |=> !cal_req);

  // R10
  no_restart_in_seq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cal_req |-> !cal_start);

  // R4
  pattern_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cal_req && $past(cal_req)) |-> $stable(cal_pattern));

  // R4
  pattern_alternates_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($countones(cal_pattern) == PAT_W / 2) && (cal_pattern[0] != cal_pattern[1]));

  // R3
  clk_force_implies_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clk_lp00 |-> data_lp00);

  // R12
  no_port_no_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_en == '0) |-> !pass);

  // R11
  all_mode_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pass && pass_all) |-> ((rx_valid & rx_en) == rx_en));

  // R11
  any_mode_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pass && !pass_all) |-> ((rx_valid & rx_en) != '0));

endmodule

bind skewcal_top skewcal_chk #(.NPORTS(NPORTS), .PAT_W(PAT_W)) chk_i (
  .clk         (clk),
  .rst_n       (rst_n),
  .cal_req     (cal_req),
  .cal_done    (cal_done),
  .link_idle   (link_idle),
  .tx_enable   (tx_enable),
  .cal_pattern (cal_pattern),
  .data_lp00   (data_lp00),
  .clk_lp00    (clk_lp00),
  .rx_en       (rx_en),
  .rx_valid    (rx_valid),
  .pass_all    (pass_all),
  .pass        (pass),
  .cal_start   (cal_start)
);

// File: tb/skewcal_top_tb_top.sv
module skewcal_top_tb_top;

  localparam int NP = 4;
  localparam int PW = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          reg_wr = 1'b0;
  logic [0:0]    reg_addr = '0;
  logic [3:0]    reg_wdata = '0;
  logic [3:0]    reg_rdata;
  logic          frame_end = 1'b0;
  logic          link_idle = 1'b0;
  logic          cal_done = 1'b0;
  logic [NP-1:0] rx_en = '0;
  logic [NP-1:0] rx_valid = '0;
  logic          cal_req;
  logic [PW-1:0] cal_pattern;
  logic          data_lp00, clk_lp00, hs_clk_cont, tx_enable, pass;

  int vectors = 0;
  int miscompares = 0;

  always #10 clk = ~clk;

  skewcal_top #(.NPORTS(NP), .PAT_W(PW), .ADDR_W(1)) dut_i (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .frame_end(frame_end),
    .link_idle(link_idle), .cal_done(cal_done), .rx_en(rx_en),
    .rx_valid(rx_valid), .cal_req(cal_req), .cal_pattern(cal_pattern),
    .data_lp00(data_lp00), .clk_lp00(clk_lp00), .hs_clk_cont(hs_clk_cont),
    .tx_enable(tx_enable), .pass(pass)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic a, input logic [3:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd_chk(input string tag, input logic a, input logic [3:0] exp);
    reg_addr = a;
    #1;
    chk(tag, reg_rdata, exp);
  endtask

  task automatic pulse_fe();
    @(negedge clk); frame_end = 1'b1;
    @(negedge clk); frame_end = 1'b0;
  endtask

  task automatic pulse_done();
    @(negedge clk); cal_done = 1'b1;
    @(negedge clk); cal_done = 1'b0;
  endtask

  task automatic idle_cycles(input int n, input string tag, input logic exp_req);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      chk(tag, cal_req, exp_req);
    end
  endtask

  function automatic logic exp_pass(input logic [NP-1:0] e, input logic [NP-1:0] v,
                                    input logic m);
    int ne = 0;
    int nok = 0;
    for (int i = 0; i < NP; i++) begin
      ne  += e[i];
      nok += e[i] & v[i];
    end
    if (ne == 0) return 1'b0;
    return m ? (nok == ne) : (nok > 0);
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    vectors++;
    miscompares++;
    $display("FAIL R1 watchdog actual=hung expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd_chk("R1 link reg", 1'b0, 4'h0);
    rd_chk("R1 cal reg", 1'b1, 4'h0);
    chk("R1 cal_req", cal_req, 0);
    chk("R1 tx_enable", tx_enable, 0);
    chk("R1 hs_clk_cont", hs_clk_cont, 0);
    chk("R1 lanes", {data_lp00, clk_lp00}, 2'b00);

    // R2 / R3 lane override sweep, out_en kept 0
    for (int c = 0; c < 4; c++) begin
      logic [3:0] v;
      v = {c[1:0], 1'b1, 1'b0};
      wr(1'b0, v);
      rd_chk("R2 link readback", 1'b0, v);
      chk("R2 hs_clk_cont", hs_clk_cont, 1);
      chk("R3 data_lp00", data_lp00, (c == 1 || c == 3));
      chk("R3 clk_lp00", clk_lp00, (c == 3));
    end
    wr(1'b0, 4'h0);

    // R11 / R12 pass sweep in both modes
    for (int m = 0; m < 2; m++) begin
      wr(1'b1, {m[0], 3'b000});
      rd_chk("R2 cal readback", 1'b1, {m[0], 3'b000});
      for (int k = 0; k < 256; k++) begin
        rx_en = k[7:4]; rx_valid = k[3:0];
        #1;
        chk(k[7:4] == 0 ? "R12 pass none enabled" : "R11 pass aggregate",
            pass, exp_pass(k[7:4], k[3:0], m[0]));
      end
    end
    wr(1'b1, 4'h0);

    // R8 single-shot blocked while output disabled
    link_idle = 1'b1;
    wr(1'b1, 4'b0010);
    idle_cycles(5, "R8 no start while disabled", 1'b0);
    rd_chk("R8 request still pending", 1'b1, 4'b0010);

    // R5 deferral to idle
    link_idle = 1'b0;
    wr(1'b0, 4'b0001);
    chk("R2 tx_enable", tx_enable, 1);
    idle_cycles(4, "R5 waits for idle", 1'b0);
    @(negedge clk); link_idle = 1'b1;
    @(negedge clk);
    chk("R5 cal_req after idle", cal_req, 1);
    chk("R4 normal pattern", cal_pattern, 8'hAA);
    idle_cycles(3, "R10 req held", 1'b1);
    pulse_done();
    chk("R10 req dropped", cal_req, 0);
    rd_chk("R6 single self-cleared", 1'b1, 4'b0000);
    idle_cycles(4, "R6 exactly one sequence", 1'b0);

    // R7 periodic with inverted pattern, request arriving mid-sequence
    link_idle = 1'b0;
    wr(1'b1, 4'b0101);
    pulse_fe();
    idle_cycles(2, "R7 periodic waits for idle", 1'b0);
    link_idle = 1'b1;
    @(negedge clk);
    chk("R7 periodic start", cal_req, 1);
    chk("R4 inverted pattern", cal_pattern, 8'h55);
    wr(1'b1, 4'b0001);
    idle_cycles(1, "R4 hold while busy", 1'b1);
    chk("R4 pattern captured at start", cal_pattern, 8'h55);
    pulse_fe();
    pulse_done();
    chk("R10 gap after done", cal_req, 0);
    @(negedge clk);
    chk("R10 mid-sequence trigger served", cal_req, 1);
    chk("R4 new polarity on next sequence", cal_pattern, 8'hAA);
    pulse_done();
    idle_cycles(4, "R7 no extra sequence", 1'b0);

    // R9 merge of single-shot and periodic
    link_idle = 1'b0;
    wr(1'b1, 4'b0011);
    pulse_fe();
    link_idle = 1'b1;
    @(negedge clk);
    chk("R9 merged start", cal_req, 1);
    pulse_done();
    rd_chk("R9 single cleared", 1'b1, 4'b0001);
    idle_cycles(4, "R9 only one sequence", 1'b0);

    // R7 frame_end ignored with periodic off
    wr(1'b1, 4'b0000);
    pulse_fe();
    idle_cycles(4, "R7 ignored when periodic off", 1'b0);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

endmodule